// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers level-sensitive interrupt requests from up to `N_SRC` peripheral sources into a pending register and drives a single interrupt line towards the processor. Each source has a software-written priority and an enable bit. The controller registers the index of the highest-priority source that is both pending and enabled. The service routine reads that index and dispatches to the matching handler. It then clears the source's pending bit by writing a one to it.

A small state machine owns the outputs. `ST_IDLE` means nothing enabled is pending, so both outputs are low. `ST_SIGNAL` means an enabled source is pending and the system is awake, so only `irq_o` is high. `ST_WAKE` means an enabled source is pending while `lp_mode_i` is high, so `irq_o` and `wake_o` are both high and the power manager sees a wake-up event. On every clock edge the machine moves to the state the current inputs call for:
- `ST_IDLE` is taken when no enabled source is pending.
- `ST_WAKE` is taken when an enabled source is pending and `lp_mode_i` is high.
- `ST_SIGNAL` is taken otherwise.

Any state can move to any other. Reset returns the machine to `ST_IDLE`.

The register port is a simple single-cycle port. Writes take effect at the clock edge that samples `reg_wr_i`. Reads are combinational from `reg_addr_i`.

The register map with the default `ADDR_W` of 6 is:

| Address | Access | Contents |
|---|---|---|
| 0 | read/write | enable mask, bit i for source i |
| 1 | read, write-1-to-clear | pending bits |
| 2 | read only | winning index in the low `IDX_W` bits |
| 32 + i | read/write | priority of source i, in the low 4 bits |

The upper half of the address space (`2**(ADDR_W-1)` + i) holds the per-source priorities.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Each `irq_req_i` bit is sampled at every clock edge and sets its pending bit. A request held high keeps its bit set, even in a cycle that writes a clear to it.
- R2: Writing address 1 clears exactly the pending bits whose data bits are 1. Bits written 0 are left unchanged.
- R3: The enable mask at address 0 reads back what was written. A masked source still latches pending, but it never raises `irq_o` or `wake_o` and never wins the index. Enabling an already pending source makes it eligible on the next edge.
- R4: Each source has a 4-bit priority at address 32+i that reads back what was written. Among enabled pending sources, the larger priority value wins. A priority change takes effect one edge after the write.
- R5: When enabled pending sources share the top priority, the lowest source index wins.
- R6: `irq_o` is registered. A request sampled at edge k raises `irq_o` after edge k+1. `irq_o` falls one edge after no enabled source is pending any more.
- R7: `win_idx_o` and address 2 carry the winning index with the same timing as `irq_o`. Both read all ones while `irq_o` is low.
- R8: `wake_o` is high only in `ST_WAKE`. It rises with the same timing as `irq_o` when `lp_mode_i` is high, and it drops one edge after `lp_mode_i` falls. A masked request never raises it.
- R9: A synchronous `rst_i` clears every enable, pending bit and priority, returns the machine to `ST_IDLE`, and sets the index to all ones.
- R10: The state machine visits `ST_IDLE`, `ST_SIGNAL` and `ST_WAKE` as described above. The visible output pairs {`irq_o`,`wake_o`} are 00, 10 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_i | input | 1 | synchronous reset, active high |
| irq_req_i | input | N_SRC | level interrupt requests, one per source |
| lp_mode_i | input | 1 | system is in a low-power mode |
| reg_wr_i | input | 1 | register write strobe |
| reg_addr_i | input | ADDR_W | register address |
| reg_wdata_i | input | DATA_W | register write data |
| reg_rdata_o | output | DATA_W | register read data, combinational |
| irq_o | output | 1 | interrupt to the processor |
| wake_o | output | 1 | wake-up event to the power manager |
| win_idx_o | output | IDX_W | index of the winning source |

## Verification
A request driven before edge k lands in pending at edge k. Arbitration of that pending state then appears on `irq_o`, `wake_o` and `win_idx_o` after edge k+1. The bench therefore drives inputs on falling edges, removes the request after the first rising edge, and samples the outputs at the falling edge that follows the second rising edge. A register write takes effect at the rising edge inside its strobe. Pending and enable readbacks are checked right after that edge. Effects on `irq_o` or the index are checked only after one further edge. The lag of `wake_o` behind `lp_mode_i` is likewise checked one edge after the change.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SIGNAL = 2'd1,
        ST_WAKE   = 2'd2
    } irq_state_e;

    localparam int unsigned OFS_ENABLE  = 0;
    localparam int unsigned OFS_PENDING = 1;
    localparam int unsigned OFS_WINNER  = 2;

endpackage

// File: rtl/prio_irq_pend.sv
module prio_irq_pend #(
    parameter int N_SRC = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [N_SRC-1:0] req_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] pend_o
);

    logic [N_SRC-1:0] pend_q;

    // A live request overrides a clear in the same cycle.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_i) | req_i;
        end
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb #(
    parameter int N_SRC  = 32,
    parameter int PRIO_W = 4,
    parameter int IDX_W  = 5
) (
    input  logic [N_SRC-1:0]        active_i,
    input  logic [N_SRC*PRIO_W-1:0] prio_i,
    output logic                    any_o,
    output logic [IDX_W-1:0]        idx_o
);

    logic [PRIO_W-1:0] best_p;
    logic [IDX_W-1:0]  best_i;
    logic              found;

    // Scan upward: strict compare keeps the lower index on a tie.
    always_comb begin
        best_p = '0;
        best_i = '0;
        found  = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (active_i[i] && (!found || prio_i[i*PRIO_W +: PRIO_W] > best_p)) begin
                found  = 1'b1;
                best_p = prio_i[i*PRIO_W +: PRIO_W];
                best_i = IDX_W'(i);
            end
        end
    end

    assign any_o = found;
    assign idx_o = best_i;

endmodule

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
    import prio_irq_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int PRIO_W = 4,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5,
    parameter int ADDR_W = 6
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    wr_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [DATA_W-1:0]       wdata_i,
    input  logic [N_SRC-1:0]        pend_i,
    input  logic [IDX_W-1:0]        idx_i,
    output logic [DATA_W-1:0]       rdata_o,
    output logic [N_SRC-1:0]        en_o,
    output logic [N_SRC*PRIO_W-1:0] prio_o,
    output logic [N_SRC-1:0]        clr_o
);

    localparam int SEL_W = ADDR_W - 1;

    logic             prio_space;
    logic [SEL_W-1:0] sel;
    logic             sel_ok;
    logic [N_SRC-1:0] en_q;

    assign prio_space = addr_i[ADDR_W-1];
    assign sel        = addr_i[SEL_W-1:0];
    assign sel_ok     = prio_space && (int'(sel) < N_SRC);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            en_q <= '0;
        end else if (wr_i && addr_i == ADDR_W'(OFS_ENABLE)) begin
            en_q <= wdata_i[N_SRC-1:0];
        end
    end

    assign clr_o = (wr_i && addr_i == ADDR_W'(OFS_PENDING)) ? wdata_i[N_SRC-1:0] : '0;
    assign en_o  = en_q;

    for (genvar g = 0; g < N_SRC; g++) begin : g_prio
        logic [PRIO_W-1:0] p_q;
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                p_q <= '0;
            end else if (wr_i && sel_ok && int'(sel) == g) begin
                p_q <= wdata_i[PRIO_W-1:0];
            end
        end
        assign prio_o[g*PRIO_W +: PRIO_W] = p_q;
    end

    always_comb begin
        rdata_o = '0;
        if (sel_ok) begin
            rdata_o = DATA_W'(prio_o[int'(sel)*PRIO_W +: PRIO_W]);
        end else if (addr_i == ADDR_W'(OFS_ENABLE)) begin
            rdata_o = DATA_W'(en_q);
        end else if (addr_i == ADDR_W'(OFS_PENDING)) begin
            rdata_o = DATA_W'(pend_i);
        end else if (addr_i == ADDR_W'(OFS_WINNER)) begin
            rdata_o = DATA_W'(idx_i);
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int PRIO_W = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int ADDR_W = ((IDX_W < 2) ? 2 : IDX_W) + 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [N_SRC-1:0]  irq_req_i,
    input  logic              lp_mode_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o,
    output logic              wake_o,
    output logic [IDX_W-1:0]  win_idx_o
);

    logic [N_SRC-1:0]        pend_q;
    logic [N_SRC-1:0]        en_q;
    logic [N_SRC-1:0]        clr;
    logic [N_SRC*PRIO_W-1:0] prio;
    logic                    any_act;
    logic [IDX_W-1:0]        arb_idx;
    logic [IDX_W-1:0]        idx_q;
    irq_state_e              state_q, state_d;

    prio_irq_pend #(.N_SRC(N_SRC)) u_pend (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .req_i  (irq_req_i),
        .clr_i  (clr),
        .pend_o (pend_q)
    );

    prio_irq_regs #(
        .N_SRC(N_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W),
        .IDX_W(IDX_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .pend_i  (pend_q),
        .idx_i   (idx_q),
        .rdata_o (reg_rdata_o),
        .en_o    (en_q),
        .prio_o  (prio),
        .clr_o   (clr)
    );

    prio_irq_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
        .active_i (pend_q & en_q),
        .prio_i   (prio),
        .any_o    (any_act),
        .idx_o    (arb_idx)
    );

    // Next-state logic: every state reaches every other.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = !any_act ? ST_IDLE : (lp_mode_i ? ST_WAKE : ST_SIGNAL);
            ST_SIGNAL: state_d = !any_act ? ST_IDLE : (lp_mode_i ? ST_WAKE : ST_SIGNAL);
            ST_WAKE:   state_d = !any_act ? ST_IDLE : (lp_mode_i ? ST_WAKE : ST_SIGNAL);
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            idx_q   <= '1;
        end else begin
            state_q <= state_d;
            idx_q   <= any_act ? arb_idx : '1;
        end
    end

    always_comb begin
        irq_o  = 1'b0;
        wake_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   begin irq_o = 1'b0; wake_o = 1'b0; end
            ST_SIGNAL: begin irq_o = 1'b1; wake_o = 1'b0; end
            ST_WAKE:   begin irq_o = 1'b1; wake_o = 1'b1; end
            default:   begin irq_o = 1'b0; wake_o = 1'b0; end
        endcase
    end

    assign win_idx_o = idx_q;

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
    parameter int N_SRC = 32,
    parameter int IDX_W = 5
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             lp_i,
    input logic             irq_i,
    input logic             wake_i,
    input logic [IDX_W-1:0] idx_i,
    input logic [N_SRC-1:0] pend_i,
    input logic [N_SRC-1:0] en_i
);

    logic [N_SRC-1:0] act_d;

    always_ff @(posedge clk_i) begin
        if (rst_i) act_d <= '0;
        else       act_d <= pend_i & en_i;
    end

    // R6: an enabled pending source raises irq one edge later
    a_r6_irq_rises: assert property (@(posedge clk_i) disable iff (rst_i)
        (|(pend_i & en_i)) |=> irq_i);

    // R6: nothing eligible drops irq one edge later
    a_r6_irq_falls: assert property (@(posedge clk_i) disable iff (rst_i)
        !(|(pend_i & en_i)) |=> !irq_i);

    // R3: the reported winner was enabled and pending
    a_r3_winner_eligible: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_i |-> act_d[idx_i]);

    // R7: idle index is all ones
    a_r7_idle_index: assert property (@(posedge clk_i) disable iff (rst_i)
        !irq_i |-> (&idx_i));

    // R8: wake only alongside irq
    a_r8_wake_with_irq: assert property (@(posedge clk_i) disable iff (rst_i)
        wake_i |-> irq_i);

    // R8: awake system gives no wake next edge
    a_r8_wake_needs_lp: assert property (@(posedge clk_i) disable iff (rst_i)
        !lp_i |=> !wake_i);

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_chk (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .lp_i   (lp_mode_i),
    .irq_i  (irq_o),
    .wake_i (wake_o),
    .idx_i  (win_idx_o),
    .pend_i (pend_q),
    .en_i   (en_q)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;

    localparam int CLK_P = 10;
    localparam int N     = 32;

    typedef struct packed {
        logic [31:0] req;
        logic [4:0]  idx;
        logic        irq;
    } vec_t;

    // priorities programmed as i % 16; source 5 masked
    localparam vec_t VECS [9] = '{
        '{32'h0000_0008, 5'd3,  1'b1},
        '{32'h0000_0204, 5'd9,  1'b1},
        '{32'h8000_8000, 5'd15, 1'b1},  // R5 tie 15 vs 31
        '{32'h0010_0080, 5'd7,  1'b1},
        '{32'h0000_0020, 5'd31, 1'b0},  // R3 masked only
        '{32'h0000_0022, 5'd1,  1'b1},
        '{32'h0000_0000, 5'd31, 1'b0},
        '{32'h0001_0001, 5'd0,  1'b1},  // R5 tie at priority 0
        '{32'hC000_0000, 5'd31, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [N-1:0] req = '0;
    logic        lp = 1'b0;
    logic        wr = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, wake;
    logic [4:0]  idx;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk_i(clk), .rst_i(rst), .irq_req_i(req), .lp_mode_i(lp),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq), .wake_o(wake), .win_idx_o(idx)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [5:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse(input logic [N-1:0] r);
        @(negedge clk); req = r;
        @(negedge clk); req = '0;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9 reset state
        chk("R9 irq", irq, 0);
        chk("R9 wake", wake, 0);
        chk("R9 idx", idx, 31);
        rd_reg(6'd0, d); chk("R9 enable", d, 0);
        rd_reg(6'd1, d); chk("R9 pending", d, 0);
        rd_reg(6'd35, d); chk("R9 prio3", d, 0);

        // R4 program and read back
        for (int i = 0; i < N; i++) wr_reg(6'(32 + i), 32'(i % 16));
        rd_reg(6'd41, d); chk("R4 prio9", d, 9);
        rd_reg(6'd63, d); chk("R4 prio31", d, 15);
        wr_reg(6'd0, ~32'h20);
        rd_reg(6'd0, d); chk("R3 enable readback", d, ~32'h20);

        // vector table
        for (int v = 0; v < 9; v++) begin
            @(negedge clk); req = VECS[v].req;
            @(negedge clk); req = '0;
            chk($sformatf("R6 latency v%0d", v), irq, 0);
            @(negedge clk);
            chk($sformatf("R6 irq v%0d", v), irq, VECS[v].irq);
            chk($sformatf("R4/R5 idx v%0d", v), idx, VECS[v].idx);
            rd_reg(6'd2, d);
            chk($sformatf("R7 idx reg v%0d", v), d, 32'(VECS[v].idx));
            chk($sformatf("R8 wake v%0d", v), wake, 0);
            wr_reg(6'd1, '1);
            @(negedge clk);
        end

        // R1 held request beats clear
        @(negedge clk); req = 32'h10;
        wr_reg(6'd1, 32'h10);
        rd_reg(6'd1, d); chk("R1 held request stays", d, 32'h10);
        req = '0;
        wr_reg(6'd1, 32'h10);
        rd_reg(6'd1, d); chk("R2 clear after release", d, 0);

        // R2 selective clear
        pulse(32'h44);
        wr_reg(6'd1, 32'h04);
        rd_reg(6'd1, d); chk("R2 selective clear", d, 32'h40);
        wr_reg(6'd1, 32'h0);
        rd_reg(6'd1, d); chk("R2 zero write keeps", d, 32'h40);
        wr_reg(6'd1, '1);
        @(negedge clk);
        chk("R6 irq falls after clear", irq, 0);

        // R8/R10 wake
        lp = 1'b1;
        pulse(32'h80);
        @(negedge clk);
        chk("R8 wake raised", wake, 1);
        chk("R10 irq in wake", irq, 1);
        chk("R7 idx in wake", idx, 7);
        lp = 1'b0;
        @(negedge clk);
        chk("R8 wake drops", wake, 0);
        chk("R10 signal state irq", irq, 1);
        lp = 1'b1;
        wr_reg(6'd1, '1);
        @(negedge clk);
        chk("R10 idle", irq, 0);
        pulse(32'h20);
        @(negedge clk);
        chk("R3 masked no irq", irq, 0);
        chk("R3 masked no wake", wake, 0);
        rd_reg(6'd1, d); chk("R3 masked still pending", d, 32'h20);
        lp = 1'b0;

        // R3 enabling pending source
        wr_reg(6'd0, '1);
        @(negedge clk);
        chk("R3 enabled irq", irq, 1);
        chk("R3 enabled idx", idx, 5);

        // R4 priority change reorders
        pulse(32'h200);
        @(negedge clk);
        chk("R4 higher wins", idx, 9);
        wr_reg(6'd37, 32'd12);
        @(negedge clk);
        chk("R4 reprioritised", idx, 5);

        // R9 mid-run reset
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R9 irq cleared", irq, 0);
        chk("R9 idx cleared", idx, 31);
        rd_reg(6'd0, d); chk("R9 enable cleared", d, 0);
        rd_reg(6'd1, d); chk("R9 pending cleared", d, 0);
        rd_reg(6'd37, d); chk("R9 prio cleared", d, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule